// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave (256 x 8)

This block is a synthesizable model of a byte-addressed serial memory that sits on a two-wire bus as a slave. It holds 256 bytes in flip-flops. An 8-bit word address counter selects the byte. The block oversamples SCL and SDA with its own system clock and detects START and STOP conditions. It decodes the address byte against three strap pins, then serves byte writes, page writes of up to 16 bytes, current-address reads, random reads and sequential reads. SDA is open-drain: the block only ever pulls the line low, through `sda_oe`.

Written bytes first collect in a 16-entry page buffer. They are committed together when the master issues STOP. A fixed busy period, counted in system clocks, then begins. During that period the block does not acknowledge its address, so a master can poll with address bytes to find out when the write has finished. When the `wp_lock` input is high, the upper half of the array (word addresses 0x80 to 0xFF) cannot be changed. The lower half stays writable.

Top module: `eeprom_2w_slave`

## Requirements
- R1: The address byte, sent MSB first, is 1010 followed by the three strap bits and then the read/write bit (1 = read). The block pulls SDA low in the ninth clock only when all seven upper bits match and no write cycle is busy. After a mismatch it neither acknowledges nor stores anything until the next START.
- R2: After reset, SDA is released, every byte reads 0x00 and the word address counter is 0x00.
- R3: A byte write (address byte, word address, one data byte, STOP) followed by a random read of that address returns the written byte. Every byte of the write is acknowledged.
- R4: In a page write, the low 4 address bits advance after each data byte and wrap within the 16-byte page, while the upper 4 bits stay fixed. When more than 16 bytes are sent, the later bytes overwrite the earlier ones.
- R5: A STOP that ends a write with at least one committed byte starts a busy period of WRITE_CYCLES clocks. While it lasts, the address byte is not acknowledged, and once it ends the address byte is acknowledged again.
- R6: With `wp_lock` high, a write to word addresses 0x80 to 0xFF is acknowledged byte by byte but leaves the array unchanged and starts no busy period. Writes to 0x00 to 0x7F still take effect, and with `wp_lock` low the upper half is writable.
- R7: A sequential read returns consecutive bytes and advances the full 8-bit counter, wrapping from 0xFF to 0x00.
- R8: A read ended by a master NACK and STOP releases SDA and leaves the counter one past the last byte read, so a following current-address read continues from there.
- R9: A START or STOP at any point restarts byte framing. A START received after data bytes discards them, so the following STOP commits nothing and starts no busy period.
- R10: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl | input | 1 | Bus clock from the master |
| sda_in | input | 1 | Sensed level of the bus data line |
| sda_oe | output | 1 | High pulls the data line low |
| a_strap | input | 3 | Strap pins compared with address bits 3..1 |
| wp_lock | input | 1 | High protects word addresses 0x80 to 0xFF |

## Verification
The bench targets page-boundary wrap, overflow past 16 bytes and the 0xFF to 0x00 wrap of sequential reads. A design that carried the increment into the upper address bits would spill bytes into the next page, and one that stopped at 0xFF would repeat the last byte. Writes to the protected half are checked to be acknowledged, to leave no data behind and to start no busy period; a design that gated only the commit would still block the bus. A START placed after data bytes, an address byte with wrong straps and ACK polling right after STOP check that aborted or foreign writes never reach the array and that the busy period blocks only the address acknowledge.

// File: rtl/eeprom_2w_slave.sv
module eeprom_2w_slave #(
  parameter int WRITE_CYCLES = 3000,
  parameter int MEM_BYTES    = 256,
  parameter int PAGE_BYTES   = 16,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl,
  input  logic       sda_in,
  output logic       sda_oe,
  input  logic [2:0] a_strap,
  input  logic       wp_lock
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int CW = $clog2(WRITE_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_WADR, S_WDAT, S_RDAT} st_t;

  st_t st;
  logic scl_q, sda_q, mack;
  logic [3:0] bitcnt;
  logic [7:0] shreg;
  logic [6:0] txbyte;
  logic [AW-1:0] addr;
  logic [CW-1:0] busy_cnt;
  logic [7:0] mem  [MEM_BYTES];
  logic [7:0] pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pvalid;

  wire scl_rise = scl & ~scl_q;
  wire scl_fall = ~scl & scl_q;
  wire start_c  = scl & scl_q & sda_q & ~sda_in;
  wire stop_c   = scl & scl_q & ~sda_q & sda_in;
  wire busy     = busy_cnt != '0;
  wire dev_hit  = shreg[7:1] == {DEV_CODE, a_strap};
  wire commit   = stop_c && st == S_WDAT && |pvalid && !(wp_lock && addr[AW-1]);
  wire [2:0] bidx = 3'd7 - bitcnt[2:0];

  assign sda_oe = mack_oe;
  logic mack_oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      mack <= 1'b0;
      mack_oe <= 1'b0;
      bitcnt <= '0;
      shreg <= '0;
      txbyte <= '0;
      addr <= '0;
      busy_cnt <= '0;
      pvalid <= '0;
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= '0;
    end else begin
      scl_q <= scl;
      sda_q <= sda_in;
      if (busy) busy_cnt <= busy_cnt - 1'b1;
      if (start_c) begin
        st <= S_DEV;
        bitcnt <= '0;
        mack_oe <= 1'b0;
        pvalid <= '0;
      end else if (stop_c) begin
        st <= S_IDLE;
        bitcnt <= '0;
        mack_oe <= 1'b0;
        pvalid <= '0;
        if (commit) begin
          for (int i = 0; i < PAGE_BYTES; i++)
            if (pvalid[i]) mem[{addr[AW-1:PW], PW'(i)}] <= pbuf[i];
          busy_cnt <= CW'(WRITE_CYCLES);
        end
      end else if (st != S_IDLE) begin
        if (scl_rise) begin
          shreg <= {shreg[6:0], sda_in};
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == 4'd8) mack <= ~sda_in;
        end
        if (scl_fall) begin
          if (bitcnt == 4'd8) begin
            mack_oe <= 1'b0;
            case (st)
              S_DEV:
                if (dev_hit && !busy) begin
                  mack_oe <= 1'b1;
                  st <= shreg[0] ? S_RDAT : S_WADR;
                end else st <= S_IDLE;
              S_WADR: begin
                addr <= shreg[AW-1:0];
                mack_oe <= 1'b1;
                st <= S_WDAT;
              end
              S_WDAT: begin
                pbuf[addr[PW-1:0]] <= shreg;
                pvalid[addr[PW-1:0]] <= 1'b1;
                addr[PW-1:0] <= addr[PW-1:0] + 1'b1;
                mack_oe <= 1'b1;
              end
              default: ;
            endcase
          end else if (bitcnt == 4'd9) begin
            bitcnt <= '0;
            mack_oe <= 1'b0;
            if (st == S_RDAT) begin
              if (mack) begin
                txbyte <= mem[addr][6:0];
                mack_oe <= ~mem[addr][7];
                addr <= addr + 1'b1;
              end else st <= S_IDLE;
            end
          end else if (st == S_RDAT && bitcnt != 4'd0) begin
            mack_oe <= ~txbyte[bidx];
          end
        end
      end
    end
  end
endmodule

module eeprom_2w_slave_chk #(
  parameter int MEM_BYTES = 256,
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl,
  input logic          sda_oe,
  input logic          wp_lock,
  input logic [2:0]    a_strap,
  input logic [2:0]    st,
  input logic [3:0]    bitcnt,
  input logic [7:0]    shreg,
  input logic [7:0]    addr,
  input logic [CW-1:0] busy_cnt,
  input logic          start_c,
  input logic          scl_fall,
  input logic [7:0]    mem [MEM_BYTES]
);
  localparam logic [2:0] C_DEV = 3'd1;
  localparam logic [2:0] C_WDAT = 3'd3;

  wire addr_phase_end = st == C_DEV && bitcnt == 4'd8 && scl_fall;

  p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl);

  p_no_ack_foreign_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_phase_end && shreg[7:1] != {4'b1010, a_strap}) |=> !sda_oe);

  p_no_ack_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_phase_end && busy_cnt != '0) |=> !sda_oe);

  p_busy_countdown_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt != '0 |=> busy_cnt == $past(busy_cnt) - 1'b1);

  p_page_hi_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_WDAT && $past(st) == C_WDAT) |-> addr[7:4] == $past(addr[7:4]));

  p_start_reframe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> (bitcnt == 4'd0 && st == C_DEV && !sda_oe));

  for (genvar i = MEM_BYTES / 2; i < MEM_BYTES; i++) begin : g_wp
    p_wp_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wp_lock |=> $stable(mem[i]));
  end
endmodule

bind eeprom_2w_slave eeprom_2w_slave_chk #(.MEM_BYTES(MEM_BYTES), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl(scl), .sda_oe(sda_oe), .wp_lock(wp_lock),
  .a_strap(a_strap), .st(st), .bitcnt(bitcnt), .shreg(shreg), .addr(addr),
  .busy_cnt(busy_cnt), .start_c(start_c), .scl_fall(scl_fall), .mem(mem)
);

// File: tb/eeprom_2w_slave_tb.sv
module eeprom_2w_slave_tb;
  localparam int WC = 300;
  localparam int HALF = 4;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic sda_oe;
  logic [2:0] strap = 3'b101;
  wire sda_bus = sda_m & ~sda_oe;

  int errs = 0, checks = 0, oe_viol = 0;
  bit done = 1'b0, prev_oe = 1'b0;
  logic [7:0] exp_mem [256];
  logic [7:0] wbuf [32];
  logic [7:0] cur_addr = 8'h00;

  always #2 clk = ~clk;

  eeprom_2w_slave #(.WRITE_CYCLES(WC)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl(scl), .sda_in(sda_bus), .sda_oe(sda_oe),
    .a_strap(strap), .wp_lock(wp)
  );

  always @(negedge clk) begin
    if (rst_n && sda_oe !== prev_oe && scl) oe_viol++;
    prev_oe = sda_oe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hw();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hw(); scl = 1'b1; hw(); sda_m = 1'b0; hw(); scl = 1'b0; hw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hw(); scl = 1'b1; hw(); sda_m = 1'b1; hw();
  endtask

  task automatic send(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hw(); scl = 1'b1; hw(); scl = 1'b0;
    end
    sda_m = 1'b1; hw(); scl = 1'b1; hw();
    ack = !sda_bus;
    scl = 1'b0; hw();
  endtask

  task automatic recv(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      hw(); scl = 1'b1; hw(); b = {b[6:0], sda_bus}; scl = 1'b0;
    end
    sda_m = !mack; hw(); scl = 1'b1; hw(); scl = 1'b0; hw();
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] devb(input logic [2:0] s, input bit rd);
    return {4'b1010, s, rd};
  endfunction

  function automatic bit lands(input logic [7:0] a, input bit lock);
    return !(lock && a[7]);
  endfunction

  task automatic model_write(input logic [7:0] a, input int n, input bit lock);
    for (int i = 0; i < n; i++)
      if (lands(a, lock)) exp_mem[{a[7:4], 4'(a[3:0] + i)}] = wbuf[i];
    cur_addr = {a[7:4], 4'(a[3:0] + n)};
  endtask

  task automatic write_seq(input logic [7:0] a, input int n, input string req);
    bit ack;
    bus_start();
    send(devb(strap, 1'b0), ack); chk(req, ack, 1);
    send(a, ack); chk(req, ack, 1);
    for (int i = 0; i < n; i++) begin
      send(wbuf[i], ack); chk(req, ack, 1);
    end
    bus_stop();
    model_write(a, n, wp);
  endtask

  task automatic poll(output bit ack);
    bus_start(); send(devb(strap, 1'b0), ack); bus_stop();
  endtask

  task automatic wait_ready();
    bit ack = 1'b0;
    for (int k = 0; k < 100 && !ack; k++) poll(ack);
  endtask

  task automatic read_seq(input logic [7:0] a, input int n, input string req);
    bit ack;
    logic [7:0] b;
    bus_start();
    send(devb(strap, 1'b0), ack); chk(req, ack, 1);
    send(a, ack); chk(req, ack, 1);
    bus_start();
    send(devb(strap, 1'b1), ack); chk(req, ack, 1);
    for (int i = 0; i < n; i++) begin
      recv(i != n - 1, b);
      chk(req, b, exp_mem[8'(a + i)]);
    end
    bus_stop();
    cur_addr = 8'(a + n);
  endtask

  task automatic cur_read(input int n, input string req);
    bit ack;
    logic [7:0] b;
    bus_start();
    send(devb(strap, 1'b1), ack); chk(req, ack, 1);
    for (int i = 0; i < n; i++) begin
      recv(i != n - 1, b);
      chk(req, b, exp_mem[cur_addr]);
      cur_addr = cur_addr + 1'b1;
    end
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] a;
    int n;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'h00;
    repeat (10) @(negedge clk);
    chk("R2 sda released in reset", sda_oe, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R2 sda released after reset", sda_oe, 0);
    cur_read(2, "R2");

    // R1: foreign straps and foreign device code are ignored
    bus_start(); send(devb(3'b100, 1'b0), ack); chk("R1 strap mismatch", ack, 0);
    send(8'h00, ack); chk("R1 ignored byte", ack, 0);
    send(8'h55, ack); chk("R1 ignored byte", ack, 0);
    bus_stop();
    bus_start(); send({4'b1011, strap, 1'b0}, ack); chk("R1 code mismatch", ack, 0); bus_stop();
    poll(ack); chk("R1 no busy after foreign", ack, 1);
    read_seq(8'h00, 1, "R1");

    // R3 / R5: byte write, busy period, ACK polling
    wbuf[0] = 8'hA5;
    write_seq(8'h10, 1, "R3");
    poll(ack); chk("R5 nack while busy", ack, 0);
    repeat (WC) @(negedge clk);
    poll(ack); chk("R5 ack after busy", ack, 1);
    read_seq(8'h10, 1, "R3");

    // R4: page wrap and overflow
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    write_seq(8'h2E, 4, "R4");
    wait_ready();
    read_seq(8'h20, 16, "R4");
    for (int i = 0; i < 18; i++) wbuf[i] = 8'(8'h60 + i);
    write_seq(8'h50, 18, "R4");
    wait_ready();
    read_seq(8'h50, 16, "R4");

    // R6: write protect of upper half
    wp = 1'b1;
    wbuf[0] = 8'hDE; wbuf[1] = 8'hAD; wbuf[2] = 8'hBE;
    write_seq(8'h90, 3, "R6");
    poll(ack); chk("R6 no busy after protected write", ack, 1);
    read_seq(8'h90, 3, "R6");
    write_seq(8'h05, 2, "R6");
    wait_ready();
    read_seq(8'h05, 2, "R6");
    wp = 1'b0;
    write_seq(8'h90, 3, "R6");
    wait_ready();
    read_seq(8'h90, 3, "R6");

    // R7 / R8: counter wrap and continuation
    wbuf[0] = 8'hC3; wbuf[1] = 8'h3C;
    write_seq(8'hFE, 2, "R7");
    wait_ready();
    read_seq(8'hFE, 4, "R7");
    cur_read(2, "R8");

    // R9: START after data discards the write
    bus_start();
    send(devb(strap, 1'b0), ack); chk("R9", ack, 1);
    send(8'h40, ack); chk("R9", ack, 1);
    send(8'h77, ack); chk("R9", ack, 1);
    bus_start();
    bus_stop();
    poll(ack); chk("R9 no busy after aborted write", ack, 1);
    read_seq(8'h40, 1, "R9");

    // constrained random mix
    for (int it = 0; it < 20; it++) begin
      a = 8'($urandom);
      n = 1 + int'($urandom % 20);
      wp = 1'($urandom);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      write_seq(a, n, "R4");
      if (lands(a, wp)) wait_ready();
      else begin
        poll(ack); chk("R6 random protected no busy", ack, 1);
      end
      wp = 1'b0;
      read_seq(8'($urandom), 1 + int'($urandom % 6), "R7");
      cur_read(1, "R8");
    end

    chk("R10 sda_oe moved with scl high", oe_viol, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule